// File: doc/BRIEF.md
# Chunk-Serial Wide Adder

This block adds two wide unsigned operands with a single narrow adder that is reused once per clock cycle. The operands are cut into `NUM_CHUNKS` chunks of `CHUNK_W` bits each. One chunk is handled per step, starting with the least significant chunk. The narrow adder's carry-out is stored in one flip-flop and fed into the next chunk's addition, so a wide sum is formed at the cost of one cycle per chunk.

A caller pulses `start` with both operands present. The block captures them and runs its chunk steps. When the last chunk has been added, it raises `done` for one cycle. The full-width sum and the final carry-out are then held until the next operation is started.

Top module: `chunk_adder`

## Requirements
- R1: After reset, `busy`, `done` and `carry_out` are 0 and `sum` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `opnd_a` and `opnd_b`, and `busy` reads 1 from the next cycle on.
- R3: Chunk i of the result, bits [i*CHUNK_W +: CHUNK_W] of `sum`, is the low CHUNK_W bits of the sum of the two operand chunks at that position plus the carry-in for that chunk. Chunks are processed from i=0 upward. When `done` is high, `sum` equals (opnd_a + opnd_b) mod 2^(CHUNK_W*NUM_CHUNKS).
- R4: The carry flip-flop is cleared when an operation is accepted, so chunk 0 is added with no carry-in even when the previous operation ended with a carry. Every later chunk adds the carry produced by the chunk below it.
- R5: When `done` is high, `carry_out` equals bit CHUNK_W*NUM_CHUNKS of opnd_a + opnd_b. `sum` and `carry_out` keep their values while the block is idle and no new `start` arrives.
- R6: `done` is high for exactly one cycle. It rises on the NUM_CHUNKS-th rising clock edge after the edge that accepted `start`, and `busy` falls on that same edge.
- R7: A `start` that arrives while `busy` is 1 is ignored. The operation in flight completes with the operands it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an addition when the block is idle |
| opnd_a | input | CHUNK_W*NUM_CHUNKS | First operand, sampled at an accepted start |
| opnd_b | input | CHUNK_W*NUM_CHUNKS | Second operand, sampled at an accepted start |
| sum | output | CHUNK_W*NUM_CHUNKS | Wide sum, valid when done is high and held afterwards |
| carry_out | output | 1 | Carry out of the most significant chunk |
| busy | output | 1 | High while chunk steps are in progress |
| done | output | 1 | One-cycle pulse when the last chunk has been added |

## Verification
The assertions assume that `start` is never X once reset is released. They also assume that operands matter only on the cycle a start is accepted, so operand values in other cycles are left unconstrained. The bench changes every input on the falling clock edge and holds reset for several cycles before the first start. It sweeps every operand pair of a 3-bit by 2-chunk instance. A default-sized instance gets ripple cases such as all-ones plus one, pseudo-random pairs, and starts injected in the middle of an operation.

// File: rtl/chunk_adder.sv
module chunk_adder #(
  parameter int CHUNK_W    = 8,
  parameter int NUM_CHUNKS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [CHUNK_W*NUM_CHUNKS-1:0] opnd_a,
  input  logic [CHUNK_W*NUM_CHUNKS-1:0] opnd_b,
  output logic [CHUNK_W*NUM_CHUNKS-1:0] sum,
  output logic                          carry_out,
  output logic                          busy,
  output logic                          done
);

  localparam int WIDTH = CHUNK_W * NUM_CHUNKS;
  localparam int IDX_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CHUNKS - 1);

  logic [WIDTH-1:0]   a_q, b_q;
  logic [IDX_W-1:0]   step_q;
  logic               carry_q;
  logic               accept;
  logic [CHUNK_W:0]   chunk_res;
  logic [CHUNK_W-1:0] sum_q [NUM_CHUNKS];

  assign accept    = start && !busy;
  assign chunk_res = {1'b0, a_q[CHUNK_W-1:0]} + {1'b0, b_q[CHUNK_W-1:0]}
                   + {{CHUNK_W{1'b0}}, carry_q};
  assign carry_out = carry_q;

  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_out
    assign sum[i*CHUNK_W +: CHUNK_W] = sum_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      step_q  <= '0;
      carry_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        a_q     <= opnd_a;
        b_q     <= opnd_b;
        carry_q <= 1'b0;
        step_q  <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        a_q     <= a_q >> CHUNK_W;
        b_q     <= b_q >> CHUNK_W;
        carry_q <= chunk_res[CHUNK_W];
        if (step_q == LAST) begin
          step_q <= '0;
          busy   <= 1'b0;
          done   <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CHUNKS; i++) sum_q[i] <= '0;
    end else if (busy && !accept) begin
      for (int i = 0; i < NUM_CHUNKS; i++)
        if (step_q == IDX_W'(i)) sum_q[i] <= chunk_res[CHUNK_W-1:0];
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r4_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (carry_q == 1'b0));

  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_done_last_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(step_q) == LAST && $past(busy)));

  a_r7_ops_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (step_q != '0 || !busy || $past(step_q) == LAST));

endmodule

// File: tb/tb_chunk_adder.sv
`timescale 1ns/1ps
module tb_chunk_adder;
  localparam int SW = 3;
  localparam int SK = 2;
  localparam int SN = SW * SK;
  localparam int WW = 8;
  localparam int WK = 4;
  localparam int WN = WW * WK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          s_start = 1'b0;
  logic [SN-1:0] s_a = '0, s_b = '0;
  logic [SN-1:0] s_sum;
  logic          s_co, s_busy, s_done;

  logic          w_start = 1'b0;
  logic [WN-1:0] w_a = '0, w_b = '0;
  logic [WN-1:0] w_sum;
  logic          w_co, w_busy, w_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  chunk_adder #(.CHUNK_W(SW), .NUM_CHUNKS(SK)) dut (
    .clk(clk), .rst_n(rst_n), .start(s_start), .opnd_a(s_a), .opnd_b(s_b),
    .sum(s_sum), .carry_out(s_co), .busy(s_busy), .done(s_done));

  chunk_adder #(.CHUNK_W(WW), .NUM_CHUNKS(WK)) dut_wide (
    .clk(clk), .rst_n(rst_n), .start(w_start), .opnd_a(w_a), .opnd_b(w_b),
    .sum(w_sum), .carry_out(w_co), .busy(w_busy), .done(w_done));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_small(input logic [SN-1:0] a, input logic [SN-1:0] b);
    logic [SN:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    s_a = a; s_b = b; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0; s_a = ~a; s_b = ~b;
    for (int n = 1; n <= SK; n++) begin
      @(negedge clk);
      if (n < SK) check(!s_done, "R6 early done", 64'(s_done), 64'd0);
    end
    check(s_done, "R6 done", 64'(s_done), 64'd1);
    check(s_sum == ref_sum[SN-1:0], "R3 sum", 64'(s_sum), 64'(ref_sum[SN-1:0]));
    check(s_co == ref_sum[SN], "R5 carry", 64'(s_co), 64'(ref_sum[SN]));
  endtask

  task automatic run_wide(input logic [WN-1:0] a, input logic [WN-1:0] b, input bit poke);
    logic [WN:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    w_a = a; w_b = b; w_start = 1'b1;
    @(negedge clk);
    w_start = 1'b0;
    check(w_busy, "R2 busy after start", 64'(w_busy), 64'd1);
    w_a = a ^ 32'h5A5A_A5A5; w_b = b + 32'd77;
    for (int n = 1; n <= WK; n++) begin
      if (poke && n == 2) w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      if (n < WK) check(!w_done && w_busy, "R6 busy no done", 64'({w_busy, w_done}), 64'b10);
    end
    check(w_done && !w_busy, "R6 done and idle", 64'({w_busy, w_done}), 64'b01);
    check(w_sum == ref_sum[WN-1:0], poke ? "R7 sum unaffected" : "R3 sum", 64'(w_sum), 64'(ref_sum[WN-1:0]));
    check(w_co == ref_sum[WN], poke ? "R7 carry unaffected" : "R5 carry", 64'(w_co), 64'(ref_sum[WN]));
    @(negedge clk);
    check(!w_done, "R6 single pulse", 64'(w_done), 64'd0);
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check(s_sum == '0 && !s_co && !s_busy && !s_done, "R1 reset small",
          64'({s_sum, s_co, s_busy, s_done}), 64'd0);
    check(w_sum == '0 && !w_co && !w_busy && !w_done, "R1 reset wide",
          64'({w_sum, w_co, w_busy, w_done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < (1 << SN); a++)
      for (int b = 0; b < (1 << SN); b++)
        run_small(SN'(a), SN'(b));

    run_wide(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    run_wide(32'h0000_0000, 32'h0000_0000, 1'b0);
    check(w_co == 1'b0, "R4 stale carry cleared", 64'(w_co), 64'd0);
    run_wide(32'h00FF_FFFF, 32'h0000_0001, 1'b0);
    run_wide(32'h0000_00FF, 32'h0000_0001, 1'b0);
    run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_wide(32'h0000_0000, 32'h0000_0000, 1'b0);
    check(w_sum == '0, "R4 zero after carry", 64'(w_sum), 64'd0);
    run_wide(32'h1234_5678, 32'h8765_4321, 1'b1);
    run_wide(32'hFF00_FF00, 32'h0100_0100, 1'b1);

    repeat (3) @(negedge clk);
    check(w_sum == 32'h0001_0000 && w_co == 1'b1, "R5 held while idle",
          64'({w_co, w_sum}), 64'h1_0001_0000);

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] x;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr * 32'd2654435761;
      run_wide(lfsr, x, (i % 7) == 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule